// File: doc/BRIEF.md
# Transition Encoded Modulation Encoder

This block turns a slow serial data line into one compact 8-bit code per 125 us frame, so that low-speed data can travel in a 64 kbps time-division channel in place of a voice sample. It watches the data line on every cycle of the 2.048 MHz clock. It splits each frame into 32 timeslots of eight clocks each. It records the timeslot of every level change, and it records any violation pulse reported by the line conditioner.

When the next frame-start strobe arrives, the block condenses the finished frame into a code word and presents it with a one-cycle valid strobe. The code holds the data level at the end of the frame, a frame type and a slot field. From these a remote decoder can rebuild the edges to within one timeslot. Edge spacings near 52 us and 104 us are recognised so that up to three closely spaced edges can share one word. A remote decoder tells the one-edge type apart from the packed 104 us type by comparing b7 with the previous word's b7, since the parity of the edge count decides whether the level changed.

Top module: `tem_encoder`

## Requirements
- R1: The strobe cycle is cycle 0 of a frame. Clock cycle c of the frame (0 to 255) lies in timeslot c/8, and a level change is credited to the timeslot of the cycle in which the new level is first presented.
- R2: On each frame strobe the word for the frame just ended is captured. valid_o is high for exactly the one cycle after that strobe. The first strobe after reset produces no valid_o.
- R3: Bit 7 of the word equals the data level presented in the last cycle before the strobe.
- R4: A frame with no level change and no violation gives bits 6:5 = 11 and bits 4:0 = 11111.
- R5: A frame with exactly one level change gives bits 6:5 = 01 and bits 4:0 = the slot of that change.
- R6: Two changes with a slot gap of 12 to 14 and a first slot of at most 17 give bits 6:5 = 10 and bits 4:0 = the first slot.
- R7: Three changes whose two gaps are each 12 to 14 slots, with a first slot of at most 4, give bits 6:5 = 10 and bits 4:0 = the first slot.
- R8: Two changes with a slot gap of 25 to 27 and a first slot of 4 or more give bits 6:5 = 00 and bits 4:0 = the first slot.
- R9: Two changes with a slot gap of 25 to 27 and a first slot of 0 to 3 give the packed type: bits 6:5 = 01, bits 4:2 = second slot minus 24, bits 1:0 = first slot.
- R10: A frame with no level change but with a violation strobe gives bits 6:5 = 11 and bits 4:0 = the violation's slot, where slot 31 is reported as 30. Any level change in the frame overrides the violation.
- R11: Any other pattern of two or more changes falls back to bits 6:5 = 01 with bits 4:0 = the first slot.
- R12: A level change presented in the strobe cycle belongs to the new frame, in slot 0, and is absent from the word captured by that strobe.
- R13: While reset is asserted, word_o is 0 and valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 2.048 MHz sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | One-cycle frame-start strobe |
| data_i | input | 1 | Conditioned data level |
| viol_i | input | 1 | One-cycle violation-pulse strobe |
| word_o | output | 8 | Code word of the last finished frame |
| valid_o | output | 1 | One-cycle strobe that a new word was captured |

## Verification
The hardest case to reach from the ports is a level change that coincides with the frame strobe. It has to be kept out of the word being closed and appear as a slot-0 change in the next one. The bench produces this by flipping data_i in the same cycle it raises frame_i. It then checks both the closed idle word and the following one-edge word. The packed 104 us type and the fallback for a near-52 us pair that starts too late both depend on exact slot offsets. The bench places edges at chosen cycle offsets and checks the words against codes worked out by hand.

// File: rtl/tem_pkg.sv
package tem_pkg;
  localparam int unsigned SLOT_W    = 5;
  localparam int unsigned CNT_W     = 3;
  localparam int unsigned GAP_NEAR  = 13;
  localparam int unsigned GAP_FAR   = 26;
  localparam int unsigned GAP_TOL   = 1;
  localparam int unsigned NEAR_MAX0 = 17;
  localparam int unsigned TRI_MAX0  = 4;
  localparam int unsigned PACK_MAX0 = 3;
  localparam int unsigned PACK_BASE = 24;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    FT_FAR   = 2'b00,
    FT_ONE   = 2'b01,
    FT_NEAR  = 2'b10,
    FT_QUIET = 2'b11
  } ftype_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    slot_t            s0;
    slot_t            s1;
    slot_t            s2;
    logic             viol;
    slot_t            vslot;
  } fstats_t;
endpackage

// File: rtl/tem_slot_timer.sv
module tem_slot_timer #(
  parameter int unsigned CYC_PER_SLOT = 8,
  parameter int unsigned SLOTS        = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_i,
  output logic [$clog2(SLOTS)-1:0]   slot_o
);
  localparam int unsigned PH_W = (CYC_PER_SLOT > 1) ? $clog2(CYC_PER_SLOT) : 1;
  localparam int unsigned SL_W = $clog2(SLOTS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_PER_SLOT - 1);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);

  logic [PH_W-1:0] phase_q;
  logic [SL_W-1:0] slot_q;

  // strobe cycle is phase 0 of slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      slot_q  <= '0;
    end else if (frame_i) begin
      phase_q <= PH_W'(1);
      slot_q  <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      if (slot_q != SL_LAST) slot_q <= slot_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign slot_o = frame_i ? '0 : slot_q;
endmodule

// File: rtl/tem_edge_tracker.sv
module tem_edge_tracker
  import tem_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    frame_i,
  input  logic    data_i,
  input  logic    viol_i,
  input  slot_t   slot_i,
  output fstats_t stats_o,
  output logic    level_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(4);

  fstats_t stats_q, base, nxt;
  logic    data_q;
  logic    edge_w;

  assign edge_w = data_i ^ data_q;

  always_comb begin
    base = frame_i ? '0 : stats_q;
    nxt  = base;
    if (edge_w) begin
      unique case (base.cnt)
        CNT_W'(0): nxt.s0 = slot_i;
        CNT_W'(1): nxt.s1 = slot_i;
        CNT_W'(2): nxt.s2 = slot_i;
        default: ;
      endcase
      if (base.cnt != CNT_SAT) nxt.cnt = base.cnt + 1'b1;
    end
    if (viol_i && !base.viol) begin
      nxt.viol  = 1'b1;
      nxt.vslot = slot_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stats_q <= '0;
      data_q  <= 1'b0;
    end else begin
      stats_q <= nxt;
      data_q  <= data_i;
    end
  end

  assign stats_o = stats_q;
  assign level_o = data_q;
endmodule

// File: rtl/tem_word_former.sv
module tem_word_former
  import tem_pkg::*;
(
  input  fstats_t    stats_i,
  input  logic       level_i,
  output logic [7:0] word_o
);
  localparam logic [SLOT_W:0] NEAR_LO = (SLOT_W+1)'(GAP_NEAR - GAP_TOL);
  localparam logic [SLOT_W:0] NEAR_HI = (SLOT_W+1)'(GAP_NEAR + GAP_TOL);
  localparam logic [SLOT_W:0] FAR_LO  = (SLOT_W+1)'(GAP_FAR - GAP_TOL);
  localparam logic [SLOT_W:0] FAR_HI  = (SLOT_W+1)'(GAP_FAR + GAP_TOL);
  localparam slot_t QUIET_SLOT = '1;
  localparam slot_t VIOL_MAX   = slot_t'((1 << SLOT_W) - 2);

  logic [SLOT_W:0] gap1, gap2;
  logic            near1, near2, far1;
  slot_t           ypart;
  ftype_e          ftype;
  slot_t           field;

  assign gap1  = {1'b0, stats_i.s1} - {1'b0, stats_i.s0};
  assign gap2  = {1'b0, stats_i.s2} - {1'b0, stats_i.s1};
  assign near1 = (gap1 >= NEAR_LO) && (gap1 <= NEAR_HI);
  assign near2 = (gap2 >= NEAR_LO) && (gap2 <= NEAR_HI);
  assign far1  = (gap1 >= FAR_LO) && (gap1 <= FAR_HI);
  assign ypart = stats_i.s1 - slot_t'(PACK_BASE);

  always_comb begin
    ftype = FT_ONE;
    field = stats_i.s0;
    unique case (stats_i.cnt)
      3'd0: begin
        ftype = FT_QUIET;
        if (!stats_i.viol)                 field = QUIET_SLOT;
        else if (stats_i.vslot > VIOL_MAX) field = VIOL_MAX;
        else                               field = stats_i.vslot;
      end
      3'd1: ;
      3'd2: begin
        if (near1 && stats_i.s0 <= slot_t'(NEAR_MAX0)) begin
          ftype = FT_NEAR;
        end else if (far1 && stats_i.s0 > slot_t'(PACK_MAX0)) begin
          ftype = FT_FAR;
        end else if (far1) begin
          field = {ypart[2:0], stats_i.s0[1:0]};  // packed type
        end
      end
      3'd3: begin
        if (near1 && near2 && stats_i.s0 <= slot_t'(TRI_MAX0)) ftype = FT_NEAR;
      end
      default: ;
    endcase
  end

  assign word_o = {level_i, ftype, field};
endmodule

// File: rtl/tem_encoder.sv
module tem_encoder
  import tem_pkg::*;
#(
  parameter int unsigned CYC_PER_SLOT = 8,
  parameter int unsigned SLOTS        = 32,
  parameter int unsigned WORD_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              data_i,
  input  logic              viol_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  fstats_t    stats;
  slot_t      slot;
  logic       level;
  logic [7:0] enc;
  logic [WORD_W-1:0] word_q;
  logic       valid_q, armed_q;

  tem_slot_timer #(.CYC_PER_SLOT(CYC_PER_SLOT), .SLOTS(SLOTS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .slot_o(slot)
  );

  tem_edge_tracker u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .data_i(data_i),
    .viol_i(viol_i), .slot_i(slot), .stats_o(stats), .level_o(level)
  );

  tem_word_former u_form (
    .stats_i(stats), .level_i(level), .word_o(enc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      valid_q <= frame_i & armed_q;
      if (frame_i) begin
        word_q  <= WORD_W'(enc);
        armed_q <= 1'b1;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/tem_encoder_chk.sv
module tem_encoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic       data_i,
  input logic [7:0] word_o,
  input logic       valid_o
);
  AST_VALID_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(frame_i)); // R2

  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_i) |-> $stable(word_o)); // R2

  AST_LEVEL_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> word_o[7] == $past(data_i, 2)); // R3

  AST_FAR_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && word_o[6:5] == 2'b00) |-> word_o[4:0] >= 5'd4); // R8
endmodule

bind tem_encoder tem_encoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .data_i(data_i),
  .word_o(word_o), .valid_o(valid_o)
);

// File: tb/tem_encoder_bench.sv
module tem_encoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       data_i = 1'b0;
  logic       viol_i = 1'b0;
  logic [7:0] word_o;
  logic       valid_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic lvl_closed;

  tem_encoder u_tem_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .data_i(data_i),
    .viol_i(viol_i), .word_o(word_o), .valid_o(valid_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [6:0] low);
    logic [7:0] exp;
    exp = {lvl_closed, low};
    checks++;
    if (valid_o !== 1'b1 || word_o !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b/%h expected=1/%h", req, valid_o, word_o, exp);
    end
  endtask

  // cycles 1..255 of a frame; -1 means unused
  task automatic run_body(input int t0, input int t1, input int t2, input int v,
                          input bit chk_drop);
    for (int c = 1; c < 256; c++) begin
      @(negedge clk_i);
      if (c == 2 && chk_drop) check_bit("R2 valid one cycle", valid_o, 1'b0);
      frame_i = 1'b0;
      if (c == t0 || c == t1 || c == t2) data_i = ~data_i;
      viol_i = (c == v);
    end
  endtask

  task automatic close_frame(input bit tog);
    @(negedge clk_i);
    frame_i = 1'b1;
    viol_i  = 1'b0;
    lvl_closed = data_i;
    if (tog) data_i = ~data_i;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    #1;
    check_bit("R13 reset valid", valid_o, 1'b0);
    checks++;
    if (word_o !== 8'h00) begin
      errors++;
      $display("FAIL R13 reset word: actual=%h expected=00", word_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    close_frame(1'b0);
    check_bit("R2 no valid on first strobe", valid_o, 1'b0);
  endtask

  task automatic t_idle;
    run_body(-1, -1, -1, -1, 1'b0);
    close_frame(1'b0);
    check_word("R4 idle", 7'b11_11111);
  endtask

  task automatic t_single;
    run_body(85, -1, -1, -1, 1'b0);   // slot 10
    close_frame(1'b0);
    check_word("R5 R1 single", 7'b01_01010);
  endtask

  task automatic t_near_pair;
    run_body(40, 144, -1, -1, 1'b1);  // slots 5, 18
    close_frame(1'b0);
    check_word("R6 near pair", 7'b10_00101);
  endtask

  task automatic t_triple;
    run_body(17, 121, 225, -1, 1'b0); // slots 2, 15, 28
    close_frame(1'b0);
    check_word("R7 triple", 7'b10_00010);
  endtask

  task automatic t_far_pair;
    run_body(33, 241, -1, -1, 1'b0);  // slots 4, 30
    close_frame(1'b0);
    check_word("R8 far pair", 7'b00_00100);
  endtask

  task automatic t_packed;
    run_body(9, 217, -1, -1, 1'b0);   // slots 1, 27
    close_frame(1'b0);
    check_word("R9 packed", 7'b01_01101);
  endtask

  task automatic t_viol;
    run_body(-1, -1, -1, 100, 1'b0);  // slot 12
    close_frame(1'b0);
    check_word("R10 violation", 7'b11_01100);
    run_body(-1, -1, -1, 250, 1'b0);  // slot 31 -> 30
    close_frame(1'b0);
    check_word("R10 violation clamp", 7'b11_11110);
    run_body(60, -1, -1, 200, 1'b0);  // edge slot 7 wins
    close_frame(1'b0);
    check_word("R10 violation overridden", 7'b01_00111);
  endtask

  task automatic t_fallback;
    run_body(20, 100, -1, -1, 1'b0);  // gap 10
    close_frame(1'b0);
    check_word("R11 odd gap", 7'b01_00010);
    run_body(145, 249, -1, -1, 1'b0); // slots 18, 31
    close_frame(1'b0);
    check_word("R11 late near pair", 7'b01_10010);
  endtask

  task automatic t_boundary;
    run_body(-1, -1, -1, -1, 1'b0);
    close_frame(1'b1);
    check_word("R12 R3 closed word", 7'b11_11111);
    run_body(-1, -1, -1, -1, 1'b0);
    close_frame(1'b0);
    check_word("R12 edge in slot 0", 7'b01_00000);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_near_pair();
    t_triple();
    t_far_pair();
    t_packed();
    t_viol();
    t_fallback();
    t_boundary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule